// File: doc/BRIEF.md
# Dual Accumulator with Shared Hex Display

The block keeps two separate 8-bit running sums. It has one push button for adding. Each clean press of that button adds the 4-bit value set on a switch group to the sum that owns that group. Both sums take their step on the same press. A single active-high reset clears both sums. Apart from the shared button and the shared reset, the two sums do not interact.

The raw button passes through a synchroniser chain and then a debouncer. The debouncer accepts a new level only after the synchronised input has differed from the accepted level for `DEB_CYCLES` consecutive clocks. A rising edge of the accepted level gives one add pulse, one clock wide.

Both sums share one four-digit seven-segment display. The display is scanned round-robin: one digit is on at a time, and each digit stays on for `SCAN_DIV` clocks. Digit enables and segment lines are both active low.

Top module: `dual_acc_display`

## Requirements
- R1: While `rst` is high, both sums are zero and stay zero, and button activity during reset causes no addition after reset is released.
- R2: One press adds its addend exactly once. A press is any button level change that lasts `DEB_CYCLES` clocks, even if it bounces first with pulses shorter than that. Holding the button longer adds nothing more.
- R3: The addends are 4-bit unsigned values (0..15). A press sets each sum to (sum + addend) mod 256, so a sum passes FF back through 00 and keeps counting.
- R4: Sum A depends only on `addend_a`, and sum B depends only on `addend_b`. A change to one addend leaves the other sum unaffected.
- R5: Digit mapping: `dig_n[0]` shows the low nibble of sum A, `dig_n[1]` the high nibble of sum A, `dig_n[2]` the low nibble of sum B, and `dig_n[3]` the high nibble of sum B.
- R6: `seg_n[6:0]` is {g,f,e,d,c,b,a} and active low. The lit patterns (active-high gfedcba) for 0..F are 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71.
- R7: Exactly one bit of `dig_n` is low at any time. The low bit moves in the order 0,1,2,3,0 and stays on each digit for `SCAN_DIV` clocks. Reset selects digit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous active-high reset, clears both sums |
| btn_add_raw | input | 1 | Unsynchronised, possibly bouncing add button |
| addend_a | input | 4 | Switch value added to sum A |
| addend_b | input | 4 | Switch value added to sum B |
| seg_n | output | 7 | Active-low segments {g,f,e,d,c,b,a} |
| dig_n | output | 4 | Active-low digit enables |

## Verification
The assertions that check the additions assume the addends are steady around the add pulse. They compare each new sum with the previous sum plus the addend one clock earlier. The bench keeps to this by changing the switch groups only after the button has been settled low for several debounce windows. Bounce bursts in the stimulus use high and low pulses of at most three clocks. Each burst is followed by a steady level that lasts three debounce windows, so every press and every release is accepted exactly once.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
   localparam int NUM_ACC = 2;
   localparam int NIB_W   = 4;
   localparam int SEG_W   = 7;

   // Active-high {g,f,e,d,c,b,a} pattern for one hex nibble
   function automatic logic [SEG_W-1:0] hex_seg(input logic [NIB_W-1:0] v);
      logic [SEG_W-1:0] p;
      case (v)
         4'h0: p = 7'h3F;
         4'h1: p = 7'h06;
         4'h2: p = 7'h5B;
         4'h3: p = 7'h4F;
         4'h4: p = 7'h66;
         4'h5: p = 7'h6D;
         4'h6: p = 7'h7D;
         4'h7: p = 7'h07;
         4'h8: p = 7'h7F;
         4'h9: p = 7'h6F;
         4'hA: p = 7'h77;
         4'hB: p = 7'h7C;
         4'hC: p = 7'h39;
         4'hD: p = 7'h5E;
         4'hE: p = 7'h79;
         default: p = 7'h71;
      endcase
      return p;
   endfunction
endpackage

// File: rtl/dacc_btn_cond.sv
module dacc_btn_cond #(
   parameter int SYNC_STAGES = 2,
   parameter int DEB_CYCLES  = 50000
) (
   input  logic clk,
   input  logic rst,
   input  logic btn_raw,
   output logic press_pulse
);
   localparam int CW = $clog2(DEB_CYCLES + 1);
   localparam logic [CW-1:0] CNT_LAST = CW'(DEB_CYCLES - 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("dacc_btn_cond: SYNC_STAGES must be at least 2");
   end
   if (DEB_CYCLES < 1) begin : g_bad_deb
      $error("dacc_btn_cond: DEB_CYCLES must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   btn_s;
   logic                   level_q;
   logic [CW-1:0]          cnt_q;
   logic                   accept;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) sync_q <= '0;
      else     sync_q <= {sync_q[SYNC_STAGES-2:0], btn_raw};
   end
   assign btn_s  = sync_q[SYNC_STAGES-1];
   assign accept = (btn_s != level_q) && (cnt_q == CNT_LAST);

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         level_q     <= 1'b0;
         cnt_q       <= '0;
         press_pulse <= 1'b0;
      end else begin
         press_pulse <= accept && btn_s;
         if (btn_s == level_q) begin
            cnt_q <= '0;
         end else if (accept) begin
            level_q <= btn_s;
            cnt_q   <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/dacc_accum.sv
module dacc_accum #(
   parameter int SUM_W = 8,
   parameter int ADD_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             add_en,
   input  logic [ADD_W-1:0] addend,
   output logic [SUM_W-1:0] sum
);
   if (ADD_W > SUM_W) begin : g_bad_w
      $error("dacc_accum: ADD_W must not exceed SUM_W");
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst)         sum <= '0;
      else if (add_en) sum <= sum + SUM_W'(addend);
   end
endmodule

// File: rtl/dacc_scan.sv
module dacc_scan
   import dacc_pkg::*;
#(
   parameter int DIGITS   = 4,
   parameter int SCAN_DIV = 1000
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [NIB_W*DIGITS-1:0] nibbles,
   output logic [SEG_W-1:0]        seg_n,
   output logic [DIGITS-1:0]       dig_n
);
   localparam int DW = $clog2(SCAN_DIV);
   localparam int SW = $clog2(DIGITS);
   localparam logic [DW-1:0] DIV_LAST = DW'(SCAN_DIV - 1);
   localparam logic [SW-1:0] SEL_LAST = SW'(DIGITS - 1);

   if (SCAN_DIV < 2) begin : g_bad_div
      $error("dacc_scan: SCAN_DIV must be at least 2");
   end
   if (DIGITS < 2) begin : g_bad_dig
      $error("dacc_scan: DIGITS must be at least 2");
   end

   logic [DW-1:0]    div_q;
   logic [SW-1:0]    sel_q;
   logic [NIB_W-1:0] cur_nib;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         div_q <= '0;
         sel_q <= '0;
      end else if (div_q == DIV_LAST) begin
         div_q <= '0;
         sel_q <= (sel_q == SEL_LAST) ? '0 : sel_q + 1'b1;
      end else begin
         div_q <= div_q + 1'b1;
      end
   end

   assign cur_nib = nibbles[sel_q*NIB_W +: NIB_W];
   assign seg_n   = ~hex_seg(cur_nib);
   assign dig_n   = ~(DIGITS'(1) << sel_q);
endmodule

// File: rtl/dual_acc_display.sv
module dual_acc_display
   import dacc_pkg::*;
#(
   parameter int SUM_W       = 8,
   parameter int ADD_W       = 4,
   parameter int SYNC_STAGES = 2,
   parameter int DEB_CYCLES  = 50000,
   parameter int SCAN_DIV    = 1000,
   localparam int DIGITS     = NUM_ACC * (SUM_W / NIB_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              btn_add_raw,
   input  logic [ADD_W-1:0]  addend_a,
   input  logic [ADD_W-1:0]  addend_b,
   output logic [SEG_W-1:0]  seg_n,
   output logic [DIGITS-1:0] dig_n
);
   localparam int ACC_DIG = SUM_W / NIB_W;

   if (SUM_W % NIB_W != 0) begin : g_bad_sum
      $error("dual_acc_display: SUM_W must be a multiple of 4");
   end

   logic                    add_pulse;
   logic [ADD_W-1:0]        addends [NUM_ACC];
   logic [SUM_W-1:0]        sums    [NUM_ACC];
   logic [NIB_W*DIGITS-1:0] nibbles;

   assign addends[0] = addend_a;
   assign addends[1] = addend_b;

   dacc_btn_cond #(
      .SYNC_STAGES(SYNC_STAGES),
      .DEB_CYCLES (DEB_CYCLES)
   ) u_btn (
      .clk        (clk),
      .rst        (rst),
      .btn_raw    (btn_add_raw),
      .press_pulse(add_pulse)
   );

   for (genvar i = 0; i < NUM_ACC; i++) begin : g_acc
      dacc_accum #(
         .SUM_W(SUM_W),
         .ADD_W(ADD_W)
      ) u_acc (
         .clk   (clk),
         .rst   (rst),
         .add_en(add_pulse),
         .addend(addends[i]),
         .sum   (sums[i])
      );
      assign nibbles[i*SUM_W +: SUM_W] = sums[i];
   end

   dacc_scan #(
      .DIGITS  (DIGITS),
      .SCAN_DIV(SCAN_DIV)
   ) u_scan (
      .clk    (clk),
      .rst    (rst),
      .nibbles(nibbles),
      .seg_n  (seg_n),
      .dig_n  (dig_n)
   );
endmodule

// File: rtl/dacc_checker.sv
module dacc_checker #(
   parameter int SUM_W  = 8,
   parameter int ADD_W  = 4,
   parameter int DIGITS = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              add_pulse,
   input logic [ADD_W-1:0]  addend_a,
   input logic [ADD_W-1:0]  addend_b,
   input logic [SUM_W-1:0]  sum_a,
   input logic [SUM_W-1:0]  sum_b,
   input logic [DIGITS-1:0] dig_n
);
   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |-> (sum_a == '0 && sum_b == '0)); // R1

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      add_pulse |=> !add_pulse); // R2

   AST_HOLD_A: assert property (@(posedge clk) disable iff (rst)
      !add_pulse |=> $stable(sum_a)); // R2

   AST_HOLD_B: assert property (@(posedge clk) disable iff (rst)
      !add_pulse |=> $stable(sum_b)); // R2

   AST_ADD_A: assert property (@(posedge clk) disable iff (rst)
      add_pulse |=> sum_a == SUM_W'($past(sum_a) + SUM_W'($past(addend_a)))); // R3

   AST_ADD_B: assert property (@(posedge clk) disable iff (rst)
      add_pulse |=> sum_b == SUM_W'($past(sum_b) + SUM_W'($past(addend_b)))); // R4

   AST_ONE_DIGIT: assert property (@(posedge clk) disable iff (rst)
      $countones(~dig_n) == 1); // R7

   AST_DIGIT_ORDER: assert property (@(posedge clk) disable iff (rst)
      !$stable(dig_n) |-> dig_n == {$past(dig_n[DIGITS-2:0]), $past(dig_n[DIGITS-1])}); // R7
endmodule

bind dual_acc_display dacc_checker #(
   .SUM_W (SUM_W),
   .ADD_W (ADD_W),
   .DIGITS(DIGITS)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .add_pulse(add_pulse),
   .addend_a (addend_a),
   .addend_b (addend_b),
   .sum_a    (sums[0]),
   .sum_b    (sums[1]),
   .dig_n    (dig_n)
);

// File: tb/dual_acc_display_bench.sv
`timescale 1ns/1ps
module dual_acc_display_bench;
   localparam int DEB  = 8;
   localparam int SCAN = 4;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       btn = 1'b0;
   logic [3:0] add_a = '0;
   logic [3:0] add_b = '0;
   logic [6:0] seg_n;
   logic [3:0] dig_n;

   int  checks = 0;
   int  errors = 0;
   bit  done   = 0;
   logic [7:0] exp_a = '0;
   logic [7:0] exp_b = '0;

   always #2.5 clk = ~clk;

   dual_acc_display #(
      .SYNC_STAGES(2),
      .DEB_CYCLES (DEB),
      .SCAN_DIV   (SCAN)
   ) u_dual_acc_display (
      .clk        (clk),
      .rst        (rst),
      .btn_add_raw(btn),
      .addend_a   (add_a),
      .addend_b   (add_b),
      .seg_n      (seg_n),
      .dig_n      (dig_n)
   );

   // R6 expected active-low pattern, from the requirement table
   function automatic logic [6:0] want_seg(input logic [3:0] v);
      logic [6:0] p;
      case (v)
         4'h0: p = 7'h3F;  4'h1: p = 7'h06;  4'h2: p = 7'h5B;  4'h3: p = 7'h4F;
         4'h4: p = 7'h66;  4'h5: p = 7'h6D;  4'h6: p = 7'h7D;  4'h7: p = 7'h07;
         4'h8: p = 7'h7F;  4'h9: p = 7'h6F;  4'hA: p = 7'h77;  4'hB: p = 7'h7C;
         4'hC: p = 7'h39;  4'hD: p = 7'h5E;  4'hE: p = 7'h79;  default: p = 7'h71;
      endcase
      return ~p;
   endfunction

   // R5 mapping of digit slot to nibble
   function automatic logic [3:0] slot_nib(input int d);
      case (d)
         0: return exp_a[3:0];
         1: return exp_a[7:4];
         2: return exp_b[3:0];
         default: return exp_b[7:4];
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // Bouncing press and release, each ending in a long steady level
   task automatic press(input int hold);
      int nb;
      nb = 1 + int'($urandom_range(4));
      for (int i = 0; i < nb; i++) begin
         btn = 1'b1; cycles(1 + int'($urandom_range(2)));
         btn = 1'b0; cycles(1 + int'($urandom_range(2)));
      end
      btn = 1'b1; cycles(hold);
      nb = int'($urandom_range(4));
      for (int i = 0; i < nb; i++) begin
         btn = 1'b0; cycles(1 + int'($urandom_range(2)));
         btn = 1'b1; cycles(1 + int'($urandom_range(2)));
      end
      btn = 1'b0; cycles(3 * DEB);
   endtask

   task automatic check_display(input string req);
      for (int d = 0; d < 4; d++) begin
         int guard = 0;
         while (dig_n != ~(4'b1 << d) && guard < 8 * SCAN) begin
            @(negedge clk); guard++;
         end
         check(dig_n == ~(4'b1 << d), "R7 digit reached", dig_n, ~(4'b1 << d));
         check(seg_n == want_seg(slot_nib(d)), req, seg_n, want_seg(slot_nib(d)));
      end
   endtask

   task automatic do_press(input int hold, input string req);
      press(hold);
      exp_a = exp_a + 8'(add_a);
      exp_b = exp_b + 8'(add_b);
      check_display(req);
   endtask

   task automatic check_scan();
      logic [3:0] prev;
      int n;
      prev = dig_n;
      while (dig_n == prev) @(negedge clk);
      prev = dig_n;
      n = 0;
      while (dig_n == prev) begin @(negedge clk); n++; end
      check(n == SCAN, "R7 dwell", n, SCAN);
      check(dig_n == {prev[2:0], prev[3]}, "R7 order", dig_n, {prev[2:0], prev[3]});
   endtask

   initial begin
      void'($urandom(32'd4242));
      cycles(3);
      // R1: reset state and presses ignored during reset
      check(dig_n == 4'b1110, "R7 reset digit", dig_n, 4'b1110);
      check(seg_n == want_seg(4'h0), "R1 reset segs", seg_n, want_seg(4'h0));
      add_a = 4'd5; add_b = 4'd9;
      press(3 * DEB);
      rst = 1'b0;
      cycles(4 * DEB);
      check_display("R1 no add from reset press");

      // R7 scan timing
      for (int k = 0; k < 4; k++) check_scan();

      // R2 and R6: directed values cover every nibble, long hold counts once
      add_a = 4'd1; add_b = 4'd0;
      do_press(3 * DEB, "R2 single add");
      do_press(20 * DEB, "R2 long hold");
      for (int v = 0; v < 16; v++) begin
         add_a = 4'(v); add_b = 4'(15 - v);
         do_press(3 * DEB, "R6 segment pattern");
      end

      // R4: one addend zero, the other moving
      add_a = 4'd0; add_b = 4'd7;
      do_press(3 * DEB, "R4 A unaffected");
      add_a = 4'd11; add_b = 4'd0;
      do_press(3 * DEB, "R4 B unaffected");

      // R3: wrap past FF
      add_a = 4'd15; add_b = 4'd15;
      for (int k = 0; k < 20; k++) do_press(3 * DEB, "R3 wrap");

      // Random addends
      for (int k = 0; k < 40; k++) begin
         add_a = 4'($urandom_range(15));
         add_b = 4'($urandom_range(15));
         do_press(3 * DEB + int'($urandom_range(20)), "R3 R4 random");
      end

      // R1: reset mid-run clears both sums
      rst = 1'b1; cycles(3);
      exp_a = '0; exp_b = '0;
      rst = 1'b0; cycles(2);
      check_display("R1 clear after run");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      cycles(150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule